// File: doc/BRIEF.md
# Interleaved Four-Bank Block Refill Sequencer

This block stands in for a main memory that is split into four banks, each one word wide, and serves whole-block refills for a cache above it. The cache presents a word address. The sequencer drops the two low bits to form the block address and spends one bus cycle taking that address in. All four banks then run one shared access of fixed latency in parallel. After that the four words stream back over a one-word path, one word per bus cycle and in bank order. A refill therefore takes 1 + 15 + 4 = 20 bus cycles, where a single bank read four times in sequence would need 65.

A bus cycle is one pulse of an internal enable that the sequencer derives by dividing the core clock. The pulse is brought out so that the requester can step in the same time base. While a refill is under way the requester sees busy, and new requests are held off. A simple write path stores one word into the bank chosen by the low address bits. It is taken only while the sequencer is idle.

Top module: `ilv_fetch_seq`

## Requirements
- R1: After a synchronous active-low reset, busy is 0, req_ready is 1 and rsp_valid is 0.
- R2: bus_tick is high for one core cycle out of every CLK_DIV, and the sequencer state changes only at core clock edges where bus_tick is high.
- R3: A request is accepted only at a bus tick while the sequencer is idle. During a refill req_ready is 0, and requests presented then are ignored: exactly four words are returned, all from the first block.
- R4: The block row is req_addr with its 2 low bits removed (req_addr >> 2). The word with index i comes from bank i, meaning the word written at address row*4 + i.
- R5: Counting the accept tick as tick 0, the word with index i is valid during the bus cycle that ends at tick 17 + i, and it is consumed at that tick.
- R6: busy is high from the accept tick until tick 20, so the whole refill lasts 20 bus cycles. At the next sample after tick 20, busy is 0 and req_ready is 1.
- R7: rsp_idx carries the index of the word being returned, counting 0, 1, 2, 3. rsp_last is high only together with index 3.
- R8: A write is performed at a bus tick while the sequencer is idle. It stores wr_data into bank wr_addr[1:0] at row wr_addr >> 2. Writes presented during a refill are ignored and leave the stored word unchanged.
- R9: rsp_valid is high only while busy, and only during the four transfer bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Refill request |
| req_addr | input | ADDR_W | Word address; the 2 low bits are ignored |
| req_ready | output | 1 | Sequencer is idle and can take a request |
| wr_valid | input | 1 | Single-word write request |
| wr_addr | input | ADDR_W | Word address of the write (low bits select the bank) |
| wr_data | input | WORD_W | Write data |
| rsp_valid | output | 1 | A returned word is on rsp_data for this bus cycle |
| rsp_data | output | WORD_W | Returned word |
| rsp_idx | output | 2 | Index of the returned word within its block |
| rsp_last | output | 1 | Fourth word of the block |
| busy | output | 1 | Refill in progress; the requester stalls |
| bus_tick | output | 1 | One-core-cycle bus-cycle enable |

## Verification
Every word of a small memory is first written with a value that depends on its address. Each block is then refilled, with the two low request bits set differently each time. A word that comes back from the wrong bank or the wrong row, or one presented in the wrong bus cycle, shows up as a data, index or tick-count mismatch. In one refill a conflicting request and a write are both held asserted for the whole transfer. That run separates correct stalling from a sequencer that restarts or accepts writes while busy, because a later refill of the targeted row must return the old data. A write made while idle, followed by a refill of the same row, shows whether the write path reaches the right bank.

// File: rtl/ilv_pkg.sv
// Shared types for the interleaved refill sequencer.
// Assumes: nothing beyond SystemVerilog 2017.
package ilv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a request
        ST_ADDR = 2'd1,   // address bus cycle
        ST_ACC  = 2'd2,   // parallel bank access
        ST_XFER = 2'd3    // streaming words back
    } fetch_st_t;
endpackage

// File: rtl/ilv_bus_tick.sv
// Bus-cycle enable generator: produces a one-core-cycle pulse every DIV
// core cycles. Assumes DIV >= 1; with DIV == 1 the pulse is always high.
module ilv_bus_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_div
            logic [CW-1:0] cnt_q;

            // Free-running divide counter, wraps at DIV-1.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (cnt_q == CW'(DIV - 1))
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end

            assign tick = (cnt_q == CW'(DIV - 1));

            assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end else begin : g_pass
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/ilv_bank.sv
// One word-wide memory bank with a single write port and a registered
// read port. Assumes the caller issues rd_en and wr_en only on bus ticks.
// The storage itself is not reset.
module ilv_bank #(
    parameter int WORD_W = 32,
    parameter int ROWS   = 16,
    parameter int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem_q [ROWS];

    // Storage write port.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem_q[wr_row] <= wr_data;
    end

    // Registered read: captures the row at the end of the access phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= mem_q[rd_row];
    end
endmodule

// File: rtl/ilv_fetch_seq.sv
// Interleaved block-refill sequencer. It accepts a word address while
// idle, spends one bus cycle on the address, runs a parallel access of
// ACC_CYC bus cycles on all banks, and then returns NBANK words one per
// bus cycle. Assumes NBANK is a power of two (4 by default) and that the
// requester samples rsp_* on bus_tick.
module ilv_fetch_seq
    import ilv_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int ROWS    = 16,
    parameter int ACC_CYC = 15,
    parameter int CLK_DIV = 4,
    parameter int NBANK   = 4,
    localparam int SEL_W  = $clog2(NBANK),
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int ADDR_W = ROW_W + SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic [SEL_W-1:0]  rsp_idx,
    output logic              rsp_last,
    output logic              busy,
    output logic              bus_tick
);
    localparam int ACC_W = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;
    localparam int TOTAL = 1 + ACC_CYC + NBANK;
    localparam int TOT_W = $clog2(TOTAL + 1);

    fetch_st_t         state_q;
    logic [ACC_W-1:0]  acc_q;
    logic [ROW_W-1:0]  row_q;
    logic [SEL_W-1:0]  idx_q;
    logic              accept;
    logic              acc_done;
    logic              wr_go;
    logic [SEL_W-1:0]  unused_lo;
    logic [WORD_W-1:0] bank_q [NBANK];

    assign unused_lo = req_addr[SEL_W-1:0];

    ilv_bus_tick #(.DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bus_tick)
    );

    assign accept   = bus_tick && (state_q == ST_IDLE) && req_valid;
    assign acc_done = bus_tick && (state_q == ST_ACC) && (acc_q == ACC_W'(ACC_CYC - 1));
    assign wr_go    = bus_tick && (state_q == ST_IDLE) && wr_valid;

    // Refill sequencing: address, parallel access, then word stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            acc_q   <= '0;
            row_q   <= '0;
            idx_q   <= '0;
        end else if (bus_tick) begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    state_q <= ST_ADDR;
                    row_q   <= req_addr[ADDR_W-1:SEL_W];
                end
                ST_ADDR: begin
                    state_q <= ST_ACC;
                    acc_q   <= '0;
                end
                ST_ACC: if (acc_q == ACC_W'(ACC_CYC - 1)) begin
                    state_q <= ST_XFER;
                    idx_q   <= '0;
                end else begin
                    acc_q <= acc_q + 1'b1;
                end
                default: if (idx_q == SEL_W'(NBANK - 1)) begin
                    state_q <= ST_IDLE;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            endcase
        end
    end

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            ilv_bank #(.WORD_W(WORD_W), .ROWS(ROWS), .ROW_W(ROW_W)) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (wr_go && (wr_addr[SEL_W-1:0] == SEL_W'(b))),
                .wr_row  (wr_addr[ADDR_W-1:SEL_W]),
                .wr_data (wr_data),
                .rd_en   (acc_done),
                .rd_row  (row_q),
                .rd_data (bank_q[b])
            );
        end
    endgenerate

    assign busy      = (state_q != ST_IDLE);
    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_XFER);
    assign rsp_idx   = idx_q;
    assign rsp_last  = (state_q == ST_XFER) && (idx_q == SEL_W'(NBANK - 1));
    assign rsp_data  = bank_q[idx_q];

    // Checker counter: bus ticks since the accept tick.
    logic [TOT_W-1:0] chk_ticks_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            chk_ticks_q <= '0;
        else if (accept)
            chk_ticks_q <= '0;
        else if (bus_tick && busy)
            chk_ticks_q <= chk_ticks_q + 1'b1;
    end

    assert_rsp_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy);

    assert_last_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> (rsp_valid && rsp_idx == SEL_W'(NBANK - 1)));

    assert_accept_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_tick && req_valid));

    assert_hold_off_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_tick |=> ($stable(busy) && $stable(rsp_idx) && $stable(rsp_valid)));

    assert_total_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_tick && rsp_last) |-> (chk_ticks_q == TOT_W'(TOTAL - 1)));
endmodule

// File: tb/ilv_fetch_seq_bench.sv
`timescale 1ns/1ps
module ilv_fetch_seq_bench;
    localparam int WORD_W = 32;
    localparam int ROWS   = 8;
    localparam int ACC    = 15;
    localparam int DIV    = 3;
    localparam int AW     = 5;
    localparam int NW     = ROWS * 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic req_ready;
    logic wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic rsp_valid;
    logic [WORD_W-1:0] rsp_data;
    logic [1:0] rsp_idx;
    logic rsp_last;
    logic busy;
    logic bus_tick;

    int errs = 0;
    int checks = 0;
    logic [WORD_W-1:0] model [NW];

    always #2.5 clk = ~clk;

    ilv_fetch_seq #(.WORD_W(WORD_W), .ROWS(ROWS), .ACC_CYC(ACC),
                    .CLK_DIV(DIV), .NBANK(4)) u_ilv_fetch_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_idx(rsp_idx), .rsp_last(rsp_last), .busy(busy), .bus_tick(bus_tick)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int a, input int seed);
        return 32'h5A000000 ^ (32'(a) << 12) ^ (32'(a) * 32'd7 + 32'(seed));
    endfunction

    task automatic wait_idle_tick();
        @(negedge clk);
        while (!(bus_tick && req_ready)) @(negedge clk);
    endtask

    task automatic do_write(input int a, input logic [31:0] d);
        wait_idle_tick();
        wr_valid = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        model[a] = d;   // R8: bank a[1:0], row a>>2
    endtask

    task automatic refill(input int a, input bit junk, input int ja);
        int n = 0;
        int words = 0;
        int row = a / 4;
        wait_idle_tick();
        req_valid = 1'b1; req_addr = AW'(a);
        @(negedge clk);
        if (junk) begin
            req_addr = AW'(ja);          // R3: conflicting request held
            wr_valid = 1'b1; wr_addr = AW'(ja); wr_data = 32'hDEAD_BEEF; // R8
        end else begin
            req_valid = 1'b0;
        end
        chk(busy === 1'b1, "R6 busy after accept", 32'(busy), 1);
        forever begin
            if (bus_tick) begin
                n++;
                chk(busy === 1'b1 && req_ready === 1'b0, "R3 held off while busy",
                    {busy, req_ready}, 2'b10);
                if (rsp_valid) begin
                    chk(n == 17 + words, "R5 word tick", n, 17 + words);
                    chk(rsp_idx == 2'(words), "R7 index", rsp_idx, words);
                    chk(rsp_data === model[row*4 + words], "R4 word data",
                        rsp_data, model[row*4 + words]);
                    chk(rsp_last === (words == 3), "R7 last flag", rsp_last, words == 3);
                    words++;
                    if (words == 4) break;
                end else begin
                    chk(n < 17, "R9 no word before transfer", n, 17);
                end
                if (n > 25) begin
                    chk(1'b0, "R5 words missing", words, 4);
                    break;
                end
            end
            @(negedge clk);
        end
        chk(n == 20, "R6 total bus cycles", n, 20);
        req_valid = 1'b0; wr_valid = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && req_ready === 1'b1 && rsp_valid === 1'b0,
            "R6 idle after refill", {busy, req_ready, rsp_valid}, 3'b010);
    endtask

    initial begin
        #(5.0 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int t0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0 && req_ready === 1'b1 && rsp_valid === 1'b0,
            "R1 reset state", {busy, req_ready, rsp_valid}, 3'b010);
        // R2 tick spacing
        while (!bus_tick) @(negedge clk);
        t0 = 0;
        @(negedge clk); t0++;
        while (!bus_tick) begin @(negedge clk); t0++; end
        chk(t0 == DIV, "R2 tick spacing", t0, DIV);
        // Fill memory
        for (int a = 0; a < NW; a++) do_write(a, pat(a, 1));
        // Refill every block, low bits varied (R4)
        for (int r = 0; r < ROWS; r++) refill(r*4 + (r % 4), 1'b0, 0);
        // Request and write held during a refill must be ignored (R3, R8)
        refill(8, 1'b1, 21);
        refill(20, 1'b0, 0);   // row 5 unchanged, exactly four words
        // Idle write then refill of the same row (R8)
        do_write(14, 32'h1234_5678);
        refill(15, 1'b0, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule